// File: doc/BRIEF.md
# 8-bit PWM Timer/Counter

This block is an 8-bit counter that advances on a selectable count event and drives two compare channels, A and B. Each channel holds its own compare value and drives one waveform pin. The wave-mode input selects one of four behaviours: a free-running count that wraps, an auto-reload count that restarts after the channel A value, a single-slope PWM, or a dual-slope (up then down) PWM whose duty point stays centred in the period. In both PWM styles the period end (TOP) is either the full 8-bit range or the channel A compare value.

The count event comes from a prescaler tick supplied by the surrounding logic, or from an edge of an external pin. The pin is synchronised on chip, and either its rising or its falling edge can be selected. A halt input freezes the block. Software reaches it through a small write port. That port loads the counter, writes either compare value, or clears event flags by writing ones. Three sticky flags report overflow, compare A and compare B, and an interrupt controller elsewhere consumes them.

The block has no streaming data path, so every pin is a plain level or strobe and nothing applies back-pressure.

Top module: `pwm_timer8`

## Requirements
- R1: While rst_n is low and after its release, before any write or count event, cnt_q is 0, all three flags are 0 and both waveform pins are 0.
- R2: In wave mode 0, each count event adds one to cnt_q modulo 256, and flag_ovf is set on the event that takes the count from 255 to 0.
- R3: The clk_sel encoding is as follows. 0 means no count events. 1 counts each cycle with pre_tick high. 2 counts falling edges of ext_pin. 3 counts rising edges of ext_pin. ext_pin passes through a two-stage synchroniser first, and pre_tick is ignored when an external source is selected.
- R4: While halt is 1, the counter does not advance and no flag is set.
- R5: In wave mode 1, the event that finds cnt_q equal to the channel A compare value loads 0 instead of incrementing. A channel in output mode 1 toggles its pin on each of its compare matches in modes 0 and 1.
- R6: A count event that finds cnt_q equal to a channel's active compare value sets that channel's flag (flag_cma for A, flag_cmb for B).
- R7: Wave mode 2 gives a single-slope PWM with TOP = 255, and mode 3 gives the same with TOP = channel A compare value. The count goes from 0 to TOP and restarts, and flag_ovf is set on the event at TOP. Output mode 2 drives the pin high exactly when cnt_q < compare or compare = TOP. Output mode 3 drives the inverse of that.
- R8: Wave modes 4 (TOP = 255) and 5 (TOP = channel A value) count up from 0 to TOP, then down to 0, reversing at each end. flag_ovf is set on the event that reaches 0. The pin levels follow the R7 rule.
- R9: In wave modes 2 to 5, a compare write goes to a shadow register. The active value takes the shadow on the count event at TOP. In modes 0 and 1, a write takes effect at once.
- R10: A write to the counter (wr_addr 0) suppresses compare matches on the next count event.
- R11: A write at wr_addr 3 clears flag_ovf, flag_cma and flag_cmb where data bits 0, 1 and 2 are one. The other flags are unchanged.
- R12: Output mode 0 holds a channel's pin at 0 in every wave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt | input | 1 | Freeze counter and flag setting when 1 |
| clk_sel | input | 2 | Count source: 0 off, 1 prescaler tick, 2 pin falling, 3 pin rising |
| pre_tick | input | 1 | Prescaler tick, one cycle per count |
| ext_pin | input | 1 | External count pin, asynchronous |
| wave_mode | input | 3 | Waveform mode 0..5 (6, 7 behave as 0) |
| cmpa_mode | input | 2 | Channel A output mode |
| cmpb_mode | input | 2 | Channel B output mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 counter, 1 compare A, 2 compare B, 3 flag clear |
| wr_data | input | 8 | Write data |
| cnt_q | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| flag_ovf | output | 1 | Overflow flag |
| flag_cma | output | 1 | Compare A match flag |
| flag_cmb | output | 1 | Compare B match flag |

## Verification
A wrong count step or reversal point shows on cnt_q at the next count event. An off-by-one TOP moves the restart to a different count within one period, which is at most 510 events. A shadow register that loads at the wrong moment shows as a duty change on the pin in the same period as the write, instead of after the next TOP. A missed compare block or a wrong flag clear mask shows on the flag pins one cycle after the offending event or write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] WM_NORMAL  = 3'd0;
  localparam logic [2:0] WM_RELOAD  = 3'd1;
  localparam logic [2:0] WM_FAST_FF = 3'd2;
  localparam logic [2:0] WM_FAST_A  = 3'd3;
  localparam logic [2:0] WM_DUAL_FF = 3'd4;
  localparam logic [2:0] WM_DUAL_A  = 3'd5;

  typedef enum logic [1:0] {CS_OFF, CS_PRE, CS_FALL, CS_RISE} csel_e;

  function automatic logic is_dual(input logic [2:0] m);
    return (m == WM_DUAL_FF) || (m == WM_DUAL_A);
  endfunction

  function automatic logic is_fast(input logic [2:0] m);
    return (m == WM_FAST_FF) || (m == WM_FAST_A);
  endfunction

  function automatic logic is_pwm(input logic [2:0] m);
    return is_dual(m) || is_fast(m);
  endfunction

  function automatic logic top_from_a(input logic [2:0] m);
    return (m == WM_RELOAD) || (m == WM_FAST_A) || (m == WM_DUAL_A);
  endfunction
endpackage

// File: rtl/tmr_clksel.sv
module tmr_clksel #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic [1:0] clk_sel,
  input  logic       pre_tick,
  input  logic       ext_pin,
  output logic       tick
);
  import tmr_pkg::*;

  logic [SYNC:0] sh;
  logic          rise, fall, src;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], ext_pin};

  assign rise = sh[SYNC-1] & ~sh[SYNC];
  assign fall = ~sh[SYNC-1] & sh[SYNC];

  always_comb begin
    unique case (csel_e'(clk_sel))
      CS_PRE:  src = pre_tick;
      CS_FALL: src = fall;
      CS_RISE: src = rise;
      default: src = 1'b0;
    endcase
  end

  assign tick = src & ~halt;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   wave_mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] top_a,
  output logic [W-1:0] cnt,
  output logic [W-1:0] top,
  output logic         cmp_en,
  output logic         ovf_evt,
  output logic         upd_evt
);
  import tmr_pkg::*;

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic         dn, ndn, blk;
  logic [W-1:0] nxt;
  logic         ovf_raw, upd_raw, dual;

  assign dual = is_dual(wave_mode);
  assign top  = top_from_a(wave_mode) ? top_a : MAXV;

  always_comb begin
    nxt     = cnt + ONE;
    ndn     = 1'b0;
    ovf_raw = 1'b0;
    upd_raw = 1'b0;
    if (dual) begin
      if (!dn) begin
        if (cnt >= top) begin
          ndn     = 1'b1;
          nxt     = (cnt == '0) ? '0 : cnt - ONE;
          upd_raw = 1'b1;
        end
      end else if (cnt == '0) begin
        ndn = 1'b0;
      end else begin
        ndn     = 1'b1;
        nxt     = cnt - ONE;
        ovf_raw = (cnt == ONE);
      end
    end else if ((wave_mode == WM_RELOAD || is_fast(wave_mode)) && cnt == top) begin
      nxt     = '0;
      ovf_raw = is_fast(wave_mode) || (cnt == MAXV);
      upd_raw = is_fast(wave_mode);
    end else begin
      ovf_raw = (cnt == MAXV);
    end
  end

  assign cmp_en  = tick & ~blk & ~cnt_wr;
  assign ovf_evt = tick & ~cnt_wr & ovf_raw;
  assign upd_evt = tick & ~cnt_wr & upd_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dn  <= 1'b0;
      blk <= 1'b0;
    end else begin
      if (cnt_wr) begin
        cnt <= wr_val;
        blk <= 1'b1;
      end else if (tick) begin
        cnt <= nxt;
        blk <= 1'b0;
      end
      if (!dual)                 dn <= 1'b0;
      else if (tick && !cnt_wr)  dn <= ndn;
    end
  end
endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   wave_mode,
  input  logic [1:0]   omode,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic         cmp_en,
  input  logic         upd_evt,
  output logic [W-1:0] act,
  output logic         match,
  output logic         wave
);
  import tmr_pkg::*;

  logic [W-1:0] shadow;
  logic         tq, lvl, pwm;

  assign pwm   = is_pwm(wave_mode);
  assign match = cmp_en & (cnt == act);
  assign lvl   = (act == top) | (cnt < act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
      tq     <= 1'b0;
    end else begin
      if (wr_cmp) shadow <= wr_val;
      if (wr_cmp && !pwm)        act <= wr_val;
      else if (pwm && upd_evt)   act <= shadow;
      if (!pwm && match) begin
        unique case (omode)
          2'd1:    tq <= ~tq;
          2'd2:    tq <= 1'b0;
          2'd3:    tq <= 1'b1;
          default: tq <= tq;
        endcase
      end
    end
  end

  always_comb begin
    if (omode == 2'd0)    wave = 1'b0;
    else if (!pwm)        wave = tq;
    else if (omode == 2'd2) wave = lvl;
    else if (omode == 2'd3) wave = ~lvl;
    else                  wave = 1'b0;
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt,
  input  logic [1:0]   clk_sel,
  input  logic         pre_tick,
  input  logic         ext_pin,
  input  logic [2:0]   wave_mode,
  input  logic [1:0]   cmpa_mode,
  input  logic [1:0]   cmpb_mode,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q,
  output logic         wave_a,
  output logic         wave_b,
  output logic         flag_ovf,
  output logic         flag_cma,
  output logic         flag_cmb
);
  localparam int NCH = 2;

  logic         tick, cmp_en, ovf_evt, upd_evt, cnt_wr;
  logic [W-1:0] top;
  logic [W-1:0] act   [NCH];
  logic [1:0]   om    [NCH];
  logic         match [NCH];
  logic         wv    [NCH];
  logic [2:0]   flags;

  assign cnt_wr = wr_en && (wr_addr == 2'd0);
  assign om[0]  = cmpa_mode;
  assign om[1]  = cmpb_mode;

  tmr_clksel #(.SYNC(SYNC)) u_cs (
    .clk(clk), .rst_n(rst_n), .halt(halt), .clk_sel(clk_sel),
    .pre_tick(pre_tick), .ext_pin(ext_pin), .tick(tick)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
    .cnt_wr(cnt_wr), .wr_val(wr_data), .top_a(act[0]), .cnt(cnt_q),
    .top(top), .cmp_en(cmp_en), .ovf_evt(ovf_evt), .upd_evt(upd_evt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_ocu #(.W(W)) u_ocu (
      .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .omode(om[ch]),
      .wr_cmp(wr_en && (wr_addr == 2'(ch + 1))), .wr_val(wr_data),
      .cnt(cnt_q), .top(top), .cmp_en(cmp_en), .upd_evt(upd_evt),
      .act(act[ch]), .match(match[ch]), .wave(wv[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      for (int i = 0; i < 3; i++) begin
        logic evt;
        evt = (i == 0) ? ovf_evt : match[i-1];
        if (evt)                                           flags[i] <= 1'b1;
        else if (wr_en && wr_addr == 2'd3 && wr_data[i])   flags[i] <= 1'b0;
      end
    end
  end

  assign wave_a   = wv[0];
  assign wave_b   = wv[1];
  assign flag_ovf = flags[0];
  assign flag_cma = flags[1];
  assign flag_cmb = flags[2];
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         halt,
  input logic [1:0]   clk_sel,
  input logic         pre_tick,
  input logic [2:0]   wave_mode,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] cnt_q,
  input logic         flag_ovf,
  input logic         flag_cma,
  input logic         flag_cmb
);
  logic cwr, dual;
  assign cwr  = wr_en && (wr_addr == 2'd0);
  assign dual = (wave_mode == 3'd4) || (wave_mode == 3'd5);

  // R2
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 3'd0 && clk_sel == 2'd1 && pre_tick && !halt && !cwr)
    |=> cnt_q == W'($past(cnt_q) + W'(1)));

  // R4
  halt_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cwr) |=> $stable(cnt_q));

  // R4
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !$rose(flag_ovf) && !$rose(flag_cma) && !$rose(flag_cmb));

  // R8
  dual_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && !cwr) |=> (cnt_q == $past(cnt_q) ||
                        cnt_q == W'($past(cnt_q) + W'(1)) ||
                        cnt_q == W'($past(cnt_q) - W'(1))));

  // R10
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> !$rose(flag_cma) && !$rose(flag_cmb));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .clk_sel(clk_sel),
  .pre_tick(pre_tick), .wave_mode(wave_mode), .wr_en(wr_en),
  .wr_addr(wr_addr), .cnt_q(cnt_q), .flag_ovf(flag_ovf),
  .flag_cma(flag_cma), .flag_cmb(flag_cmb)
);

// File: tb/sim_pwm_timer8.sv
module sim_pwm_timer8;
  logic       clk = 1'b0, rst_n = 1'b0, halt = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       pre_tick = 1'b0, ext_pin = 1'b0;
  logic [2:0] wave_mode = 3'd0;
  logic [1:0] cmpa_mode = 2'd0, cmpb_mode = 2'd0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] cnt_q;
  logic       wave_a, wave_b, flag_ovf, flag_cma, flag_cmb;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_timer8 u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [2:0] m, input logic [1:0] am, input logic [1:0] bm,
                       input logic [7:0] va, input logic [7:0] vb, input logic [7:0] c);
    clk_sel = 2'd0; pre_tick = 1'b1; wave_mode = 3'd0;
    wr(2'd1, va); wr(2'd2, vb); wr(2'd0, c); wr(2'd3, 8'h07);
    wave_mode = m; cmpa_mode = am; cmpb_mode = bm;
    clk_sel = 2'd1;
  endtask

  function automatic int lvl(input int v, input int top, input int c);
    return (v == top || c < v) ? 1 : 0;
  endfunction

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int c0, w0, ec, act_b, p;
    int vals[7] = '{0, 1, 64, 128, 200, 254, 255};
    int dvals[5] = '{0, 1, 100, 254, 255};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_q, 0); chk("R1 ovf", flag_ovf, 0);
    chk("R1 cma", flag_cma, 0); chk("R1 cmb", flag_cmb, 0);
    chk("R1 wave_a", wave_a, 0); chk("R1 wave_b", wave_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt after release", cnt_q, 0);

    // R2 free count, R6 compare flags
    setup(3'd0, 2'd0, 2'd0, 8'd5, 8'd200, 8'd0);
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      chk("R2 cnt", cnt_q, k % 256);
      chk("R2 ovf", flag_ovf, k >= 256);
      chk("R6 cma", flag_cma, k >= 6);
      chk("R6 cmb", flag_cmb, k >= 201);
    end
    // R3 source off
    clk_sel = 2'd0; c0 = cnt_q;
    repeat (20) begin @(negedge clk); chk("R3 stopped", cnt_q, c0); end
    // R4 halt
    clk_sel = 2'd1; halt = 1'b1;
    wr(2'd3, 8'h07);
    repeat (20) begin
      @(negedge clk);
      chk("R4 cnt frozen", cnt_q, c0);
      chk("R4 no flags", {flag_ovf, flag_cma, flag_cmb}, 0);
    end
    halt = 1'b0;
    @(negedge clk);
    chk("R4 resume", cnt_q, (c0 + 1) % 256);

    // R10 blocked match, R11 selective clear
    setup(3'd0, 2'd0, 2'd0, 8'd0, 8'd10, 8'd10);
    for (int k = 1; k <= 260; k++) begin
      @(negedge clk);
      chk("R10 cnt", cnt_q, (10 + k) % 256);
      chk("R10 cmb", flag_cmb, k >= 257);
      chk("R2 ovf", flag_ovf, k >= 246);
    end
    clk_sel = 2'd0;
    wr(2'd3, 8'h04);
    chk("R11 cmb cleared", flag_cmb, 0); chk("R11 ovf kept", flag_ovf, 1);
    wr(2'd3, 8'h01);
    chk("R11 ovf cleared", flag_ovf, 0);

    // R5 auto-reload and toggle, R12 disabled pin
    setup(3'd1, 2'd1, 2'd0, 8'd9, 8'd4, 8'd0);
    w0 = wave_a;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      chk("R5 cnt", cnt_q, k % 10);
      chk("R5 toggle", wave_a, w0 ^ ((k / 10) & 1));
      chk("R6 cmb", flag_cmb, k >= 5);
      chk("R12 wave_b", wave_b, 0);
    end

    // R7 single-slope, TOP 255
    foreach (vals[i]) begin
      setup(3'd2, 2'd2, 2'd3, 8'(vals[i]), 8'(vals[i]), 8'd0);
      for (int k = 1; k <= 520; k++) begin
        @(negedge clk);
        ec = k % 256;
        chk("R7 cnt", cnt_q, ec);
        chk("R7 wave_a", wave_a, lvl(vals[i], 255, ec));
        chk("R7 wave_b", wave_b, 1 - lvl(vals[i], 255, ec));
        chk("R7 ovf", flag_ovf, k >= 256);
      end
    end

    // R7 single-slope, TOP from channel A
    setup(3'd3, 2'd0, 2'd2, 8'd99, 8'd30, 8'd0);
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      ec = k % 100;
      chk("R7 cnt topA", cnt_q, ec);
      chk("R7 wave_b topA", wave_b, ec < 30);
      chk("R12 wave_a", wave_a, 0);
      chk("R7 ovf topA", flag_ovf, k >= 100);
    end

    // R8 dual slope
    foreach (dvals[i]) begin
      setup(3'd4, 2'd2, 2'd3, 8'(dvals[i]), 8'(dvals[i]), 8'd0);
      for (int k = 1; k <= 1030; k++) begin
        @(negedge clk);
        p = k % 510;
        ec = (p <= 255) ? p : 510 - p;
        chk("R8 cnt", cnt_q, ec);
        chk("R8 wave_a", wave_a, lvl(dvals[i], 255, ec));
        chk("R8 wave_b", wave_b, 1 - lvl(dvals[i], 255, ec));
        chk("R8 ovf", flag_ovf, k >= 510);
      end
    end

    // R9 shadowed compare write
    setup(3'd2, 2'd0, 2'd2, 8'd0, 8'd50, 8'd0);
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      ec = k % 256;
      act_b = (k < 256) ? 50 : 100;
      chk("R9 cnt", cnt_q, ec);
      chk("R9 wave_b", wave_b, ec < act_b);
      if (k == 20) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd100; end
      else wr_en = 1'b0;
    end

    // R3 external edges, pre_tick ignored
    setup(3'd0, 2'd0, 2'd0, 8'd0, 8'd0, 8'd0);
    clk_sel = 2'd0; ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    clk_sel = 2'd3; pre_tick = 1'b1;
    pulses(8);
    repeat (4) @(negedge clk);
    chk("R3 rising edges", cnt_q, 8);
    clk_sel = 2'd2;
    pulses(8);
    repeat (4) @(negedge clk);
    chk("R3 falling edges", cnt_q, 16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule